// File: doc/BRIEF.md
# Open-Drain Single-Line Bit Slot Master

This block generates exactly one time slot per accepted request on a shared, open-drain, single-wire data line. A request asks for one of three slot kinds: send a one, send a zero, or fetch one bit from the remote device. Every slot starts with the master pulling the line low. The length of that pull-down depends on the slot kind. The line is then released for the rest of a fixed slot length, and a recovery interval with the line released follows.

For a fetch slot, the block takes one sample of the synchronized line level at a fixed cycle inside the slot. A low level gives 0 and a high level gives 1. The result is presented on `rd_bit` together with a single-cycle `rd_valid` pulse. The raw line input first passes through a chain of synchronizer flops. All durations are parameters counted in clock cycles. With the default values (one cycle per microsecond), the low time is 6 cycles for a one, 60 for a zero and 6 for a fetch. The sample is taken at cycle 14, the slot lasts 70 cycles and recovery lasts 5.

The controller is a five-state machine:
- `ST_IDLE`: ready, line released. A request moves it to `ST_LOW`.
- `ST_LOW`: line pulled down. When the kind's low time is used up, it moves to `ST_RELEASE`.
- `ST_RELEASE`: line released. The fetch sample is taken here. When the slot length is reached, it moves to `ST_RECOVER`.
- `ST_RECOVER`: after the recovery count it moves to `ST_IDLE` if the synchronized line is high, otherwise to `ST_WAIT_HIGH`.
- `ST_WAIT_HIGH`: it moves to `ST_IDLE` once the synchronized line is high.

Top module: `ow_bit_master`

## Requirements
- R1: During and right after reset, `line_pd_n` is 1 (line released), `req_ready` is 1 and `rd_valid` is 0.
- R2: A send-one request (`req_rd`=0, `req_bit`=1) drives `line_pd_n` to 0 for exactly W1_LOW (6) consecutive cycles, starting the cycle after acceptance.
- R3: A send-zero request (`req_rd`=0, `req_bit`=0) drives `line_pd_n` to 0 for exactly W0_LOW (60) consecutive cycles.
- R4: A fetch request (`req_rd`=1) drives `line_pd_n` to 0 for exactly RD_LOW (6) consecutive cycles.
- R5: In a fetch slot, `rd_valid` is high for exactly one cycle, RD_SAMPLE+1 cycles after the acceptance edge. `rd_bit` is 0 if the line was low at the sample point and 1 if it was high.
- R6: `req_ready` drops on the acceptance edge. If the line is high when recovery ends, `req_ready` stays low for exactly SLOT_LEN+REC_LEN (75) cycles. `line_pd_n` falls only once per slot.
- R7: If the line is still low at the end of recovery, `req_ready` stays low until the synchronized line is seen high, and rises within a few cycles of the line rising.
- R8: A send slot never raises `rd_valid`.
- R9: `req_rd` and `req_bit` are captured on acceptance. Changing them during a slot does not change that slot's low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Slot request |
| req_rd | input | 1 | 1 = fetch slot, 0 = send slot |
| req_bit | input | 1 | Bit to send in a send slot |
| req_ready | output | 1 | Block idle; a request is accepted when both `req_valid` and `req_ready` are high |
| rd_valid | output | 1 | One-cycle pulse marking a fetched bit |
| rd_bit | output | 1 | Fetched bit |
| line_pd_n | output | 1 | Active-low pull-down enable for the line driver |
| line_raw | input | 1 | Raw line level |

## Verification
A wrong state or counter value shows up first as a wrong pull-down width on `line_pd_n`, within the first 60 cycles of the slot. Later, it shows as a `req_ready` gap other than 75 cycles. A mix-up of the slot kind shows as a low time that belongs to another kind, or as an `rd_valid` pulse in a send slot. A missed wait-for-high shows as `req_ready` rising while the line is still held low by the remote device, which the bench catches on the first cycle of the bad `req_ready`.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_RELEASE,
        ST_RECOVER,
        ST_WAIT_HIGH
    } ow_state_t;

    typedef enum logic [1:0] {
        KIND_W0,
        KIND_W1,
        KIND_RD
    } ow_kind_t;

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_s
);

    logic [STAGES-1:0] stage_q;

    // first stage takes the asynchronous level; idle line reads high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= 1'b1;
        else        stage_q[0] <= line_raw;
    end

    for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[gi] <= 1'b1;
            else        stage_q[gi] <= stage_q[gi-1];
        end
    end

    assign line_s = stage_q[STAGES-1];

endmodule

// File: rtl/ow_slot_timer.sv
module ow_slot_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (run) cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
    import ow_slot_pkg::*;
#(
    parameter int W1_LOW    = 6,
    parameter int W0_LOW    = 60,
    parameter int RD_LOW    = 6,
    parameter int RD_SAMPLE = 14,
    parameter int SLOT_LEN  = 70,
    parameter int REC_LEN   = 5,
    parameter int CNT_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_rd,
    input  logic             req_bit,
    input  logic             line_s,
    input  logic [CNT_W-1:0] cnt,
    output logic             req_ready,
    output logic             line_pd_n,
    output logic             rd_valid,
    output logic             rd_bit,
    output logic             cnt_clr,
    output logic             cnt_run
);

    localparam logic [CNT_W-1:0] W1_LAST   = CNT_W'(W1_LOW - 1);
    localparam logic [CNT_W-1:0] W0_LAST   = CNT_W'(W0_LOW - 1);
    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_LOW - 1);
    localparam logic [CNT_W-1:0] SAMP_AT   = CNT_W'(RD_SAMPLE);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_LEN - 1);
    localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(REC_LEN - 1);

    ow_state_t state_q, state_d;
    ow_kind_t  kind_q;
    logic      low_done;
    logic      slot_done;
    logic      rec_done;
    logic      take_sample;

    // end of the pull-down phase for the captured slot kind
    always_comb begin
        unique case (kind_q)
            KIND_RD: low_done = (cnt == RD_LAST);
            KIND_W1: low_done = (cnt == W1_LAST);
            default: low_done = (cnt == W0_LAST);
        endcase
    end

    assign slot_done   = (cnt == SLOT_LAST);
    assign rec_done    = (cnt == REC_LAST);
    assign take_sample = (state_q == ST_RELEASE) && (kind_q == KIND_RD) && (cnt == SAMP_AT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_LOW;
            ST_LOW:       if (low_done)  state_d = ST_RELEASE;
            ST_RELEASE:   if (slot_done) state_d = ST_RECOVER;
            ST_RECOVER:   if (rec_done)  state_d = line_s ? ST_IDLE : ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (line_s)    state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_W1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid)
                kind_q <= req_rd ? KIND_RD : (req_bit ? KIND_W1 : KIND_W0);
        end
    end

    // fetched bit and its strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_bit   <= 1'b0;
        end else begin
            rd_valid <= take_sample;
            if (take_sample) rd_bit <= line_s;
        end
    end

    // outputs decoded from the state
    always_comb begin
        req_ready = 1'b0;
        line_pd_n = 1'b1;
        cnt_clr   = 1'b0;
        cnt_run   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                cnt_clr   = 1'b1;
            end
            ST_LOW: begin
                line_pd_n = 1'b0;
                cnt_run   = 1'b1;
            end
            ST_RELEASE: begin
                cnt_run = 1'b1;
                cnt_clr = slot_done;
            end
            ST_RECOVER: begin
                cnt_run = 1'b1;
            end
            default: begin
            end
        endcase
    end

    AST_W1_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && kind_q == KIND_W1) |-> (cnt <= W1_LAST)); // R2
    AST_W0_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && kind_q == KIND_W0) |-> (cnt <= W0_LAST)); // R3
    AST_RD_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && kind_q == KIND_RD) |-> (cnt <= RD_LAST)); // R4
    AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R5
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !line_pd_n)); // R6
    AST_WAIT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && rec_done && !line_s) |=> !req_ready); // R7
    AST_RDV_FETCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (kind_q == KIND_RD)); // R8

endmodule

// File: rtl/ow_bit_master.sv
module ow_bit_master #(
    parameter int W1_LOW      = 6,
    parameter int W0_LOW      = 60,
    parameter int RD_LOW      = 6,
    parameter int RD_SAMPLE   = 14,
    parameter int SLOT_LEN    = 70,
    parameter int REC_LEN     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_rd,
    input  logic req_bit,
    output logic req_ready,
    output logic rd_valid,
    output logic rd_bit,
    output logic line_pd_n,
    input  logic line_raw
);

    localparam int MAX_SPAN = (SLOT_LEN > REC_LEN) ? SLOT_LEN : REC_LEN;
    localparam int CNT_W    = $clog2(MAX_SPAN + 1);

    logic             line_s;
    logic             cnt_clr;
    logic             cnt_run;
    logic [CNT_W-1:0] cnt;

    ow_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_raw (line_raw),
        .line_s   (line_s)
    );

    ow_slot_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .run   (cnt_run),
        .cnt   (cnt)
    );

    ow_slot_fsm #(
        .W1_LOW    (W1_LOW),
        .W0_LOW    (W0_LOW),
        .RD_LOW    (RD_LOW),
        .RD_SAMPLE (RD_SAMPLE),
        .SLOT_LEN  (SLOT_LEN),
        .REC_LEN   (REC_LEN),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_rd    (req_rd),
        .req_bit   (req_bit),
        .line_s    (line_s),
        .cnt       (cnt),
        .req_ready (req_ready),
        .line_pd_n (line_pd_n),
        .rd_valid  (rd_valid),
        .rd_bit    (rd_bit),
        .cnt_clr   (cnt_clr),
        .cnt_run   (cnt_run)
    );

endmodule

// File: tb/test_ow_bit_master.sv
module test_ow_bit_master;

    localparam int W1_LOW    = 6;
    localparam int W0_LOW    = 60;
    localparam int RD_LOW    = 6;
    localparam int RD_SAMPLE = 14;
    localparam int SLOT_LEN  = 70;
    localparam int REC_LEN   = 5;
    localparam int BUSY_LEN  = SLOT_LEN + REC_LEN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_rd = 1'b0;
    logic req_bit = 1'b0;
    logic req_ready, rd_valid, rd_bit, line_pd_n;
    logic slave_pd = 1'b0;
    logic line_raw;

    assign line_raw = line_pd_n & ~slave_pd;

    always #4 clk = ~clk;

    ow_bit_master i_ow_bit_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_rd    (req_rd),
        .req_bit   (req_bit),
        .req_ready (req_ready),
        .rd_valid  (rd_valid),
        .rd_bit    (rd_bit),
        .line_pd_n (line_pd_n),
        .line_raw  (line_raw)
    );

    int n_checks = 0;
    int n_fail   = 0;

    int    q_low[$];
    string q_low_tag[$];
    int    q_rd[$];
    int    q_busy[$];

    int cfg_hold = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        check(q_low.size() == 0 && q_rd.size() == 0 && q_busy.size() == 0, "R6",
              q_low.size() + q_rd.size() + q_busy.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // remote device model: holds the line low after the master's falling edge
    int  hold_left = 0;
    logic slv_prev_pd = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            slave_pd    = 1'b0;
            hold_left   = 0;
            slv_prev_pd = 1'b1;
        end else begin
            if (slv_prev_pd && !line_pd_n && cfg_hold > 0) begin
                slave_pd  = 1'b1;
                hold_left = cfg_hold;
            end else if (hold_left > 0) begin
                hold_left--;
                if (hold_left == 0) slave_pd = 1'b0;
            end
            slv_prev_pd = line_pd_n;
        end
    end

    // monitor: pops expected items and compares
    int   low_cnt = 0;
    int   busy_cnt = 0;
    int   lows_in_busy = 0;
    int   high_run = 0;
    logic mon_prev_pd = 1'b1;
    logic mon_prev_rdv = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!line_pd_n) begin
                low_cnt++;
            end else if (low_cnt > 0) begin
                if (q_low.size() == 0) begin
                    check(1'b0, "R6", low_cnt, 0);
                end else begin
                    automatic int    e = q_low.pop_front();
                    automatic string t = q_low_tag.pop_front();
                    check(low_cnt == e, t, low_cnt, e);
                end
                low_cnt = 0;
            end
            if (!line_pd_n && mon_prev_pd) begin
                lows_in_busy++;
                if (lows_in_busy > 1) check(1'b0, "R6", lows_in_busy, 1);
            end
            if (!req_ready) busy_cnt++;
            if (rd_valid) begin
                check(!mon_prev_rdv, "R5", 1, 0);
                if (q_rd.size() == 0) begin
                    check(1'b0, "R8", 1, 0);
                end else begin
                    automatic int eb = q_rd.pop_front();
                    check(int'(rd_bit) == eb, "R5", int'(rd_bit), eb);
                    check(busy_cnt == RD_SAMPLE + 2, "R5", busy_cnt, RD_SAMPLE + 2);
                end
            end
            if (line_raw) high_run++;
            else          high_run = 0;
            if (req_ready && busy_cnt > 0) begin
                if (q_busy.size() == 0) begin
                    check(1'b0, "R6", busy_cnt, 0);
                end else begin
                    automatic int ex = q_busy.pop_front();
                    if (ex >= 0) begin
                        check(busy_cnt == ex, "R6", busy_cnt, ex);
                    end else begin
                        check(busy_cnt > BUSY_LEN, "R7", busy_cnt, BUSY_LEN + 1);
                        check(high_run >= 2 && high_run <= 5, "R7", high_run, 4);
                    end
                end
                busy_cnt     = 0;
                lows_in_busy = 0;
            end
            mon_prev_pd  = line_pd_n;
            mon_prev_rdv = rd_valid;
        end
    end

    // driver: issue one slot and push the expectations
    task automatic run_slot(input bit rd, input bit b, input int hold, input int exp_low,
                            input string tag, input int exp_rd, input int exp_busy,
                            input bit flip);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_hold = hold;
        q_low.push_back(exp_low);
        q_low_tag.push_back(tag);
        if (exp_rd >= 0) q_rd.push_back(exp_rd);
        q_busy.push_back(exp_busy);
        req_valid = 1'b1;
        req_rd    = rd;
        req_bit   = b;
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) req_bit = ~b;
        while (!req_ready) @(negedge clk);
        cfg_hold = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WATCHDOG", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        check(line_pd_n == 1'b1, "R1", int'(line_pd_n), 1);
        check(req_ready == 1'b1, "R1", int'(req_ready), 1);
        check(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_pd_n == 1'b1 && req_ready == 1'b1 && rd_valid == 1'b0, "R1",
              int'({line_pd_n, req_ready, rd_valid}), 6);

        run_slot(1'b0, 1'b1, 0,  W1_LOW, "R2", -1, BUSY_LEN, 1'b0); // R2 send one
        run_slot(1'b0, 1'b0, 0,  W0_LOW, "R3", -1, BUSY_LEN, 1'b0); // R3 send zero
        run_slot(1'b1, 1'b0, 30, RD_LOW, "R4", 0,  BUSY_LEN, 1'b0); // R4 R5 fetch 0
        run_slot(1'b1, 1'b1, 0,  RD_LOW, "R4", 1,  BUSY_LEN, 1'b0); // R5 fetch 1
        run_slot(1'b0, 1'b0, 0,  W0_LOW, "R9", -1, BUSY_LEN, 1'b1); // R9 flip after accept
        run_slot(1'b0, 1'b1, 0,  W1_LOW, "R9", -1, BUSY_LEN, 1'b1); // R9 flip after accept
        run_slot(1'b1, 1'b1, 25, RD_LOW, "R4", 0,  BUSY_LEN, 1'b0); // R5 fetch 0
        run_slot(1'b0, 1'b1, 100, W1_LOW, "R2", -1, -1,      1'b0); // R7 stretched low
        run_slot(1'b1, 1'b0, 0,  RD_LOW, "R4", 1,  BUSY_LEN, 1'b0); // R5 after stretch
        run_slot(1'b0, 1'b0, 90, W0_LOW, "R3", -1, -1,      1'b0); // R7 R8 stretched zero
        run_slot(1'b0, 1'b1, 0,  W1_LOW, "R8", -1, BUSY_LEN, 1'b0); // R8 no strobe
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule